// File: doc/BRIEF.md
# ECC Read-Modify-Write Write Engine

This block sits between a host request port and a memory whose words carry 8 error-check bits beside 64 data bits. A write whose byte enables cover the whole configured width is encoded and written straight to the array. Any narrower write becomes an atomic sequence. The engine reads the full stored word, checks it and repairs a single flipped bit, merges the new bytes under the byte enables, re-encodes the merged word, and writes word and check bits back together. The host port is held not-ready from acceptance until the write-back is issued, so nothing can slip in between the read and the write.

Reads take the same check-and-repair path and return the repaired data. Error events update a small status block. A sticky interrupt marks uncorrectable errors, a second sticky flag marks repaired ones, and a register keeps the address of the most recent faulty word. A one-cycle clear input drops both flags. In 32-bit mode only the low half of the data and the low four byte enables count. The upper 32 data bits are treated as zero, both when check bits are formed and when they are checked.

The array sits outside the block behind a one-cycle synchronous read port. This lets any stored word be corrupted on purpose between accesses.

Top module: `ecc_rmw_engine`

## Requirements
- R1: A write whose effective byte enables are all set (8'hFF in 64-bit mode, low nibble 4'hF in 32-bit mode) causes exactly one array write and no array read, and the host port stays ready.
- R2: Any other write (including byte enables of zero) causes one array read, then one array write to the same address. Bytes with their enable set take the new data, and the others keep the stored (repaired) data. req_ready is low for exactly two cycles after the accepting edge.
- R3: A single flipped bit anywhere in the 72-bit stored word (data, Hamming bits or overall parity bit) is repaired before use, and err_corr is set with err_addr holding the word address.
- R4: When two bits are flipped, the access still completes. A write stores the merge of the unrepaired read data with a check field valid for it, and err_irq is set.
- R5: With cfg_narrow high, only req_be[3:0] and req_wdata[31:0] are used. A write is partial when req_be[3:0] differs from 4'hF. Stored data bits [63:32] are zero, and the check field is computed over the zero-extended word.
- R6: A read pulses rsp_valid once, two edges after acceptance. rsp_rdata carries the repaired word, or the raw stored data when the error is uncorrectable. A double error on a read sets err_irq.
- R7: err_irq and err_corr stay set until an err_clr pulse. err_addr holds the address of the latest erroneous access.
- R8: After reset, req_ready is 1 and rsp_valid, mem_rd, mem_wr, err_irq and err_corr are 0.
- R9: Stored word layout is mem_wdata[63:0] = data and mem_wdata[71:64] = check. Data bit i occupies the i-th non-power-of-two position in 1..71, in increasing order. Check bit j (0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | 1 selects 32-bit data mode |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 64 | Read data |
| mem_rd | output | 1 | Array read strobe |
| mem_wr | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 72 | Array write word with check bits |
| mem_rdata | input | 72 | Array read word, one cycle after mem_rd |
| err_irq | output | 1 | Sticky uncorrectable-error interrupt |
| err_corr | output | 1 | Sticky corrected-error flag |
| err_addr | output | ADDR_W | Address of latest erroneous word |
| err_clr | input | 1 | Clears both error flags |

## Verification
Writes are driven with full masks, empty masks, single-byte and random masks. Full masks separate the direct path from the read-modify-write path. Empty masks show that a partial write rewrites the repaired word unchanged. Each access is combined with no fault, a single flip at a random or edge bit (bit 0, a Hamming bit, the overall parity bit 71), or a double flip. This distinguishes repair-before-merge from merge-of-raw-data and corrected from uncorrectable reporting. The 32-bit pass repeats this with junk in the upper data lanes and byte enables, showing that those lanes are ignored and that the check field follows the zero-extended word.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int CODE_W  = DATA_W + CHK_W;
  localparam int BYTE_W  = 8;
  localparam int BYTES   = DATA_W / BYTE_W;
  localparam int MAX_POS = DATA_W + HAM_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK} rmw_state_e;

  // codeword position of data bit idx: skip powers of two
  function automatic int data_pos(input int idx);
    int p;
    p = 0;
    for (int i = 0; i <= idx; i++) begin
      p = p + 1;
      while ((p & (p - 1)) == 0) p = p + 1;
    end
    return p;
  endfunction

  // data bits that feed Hamming check bit j
  function automatic logic [DATA_W-1:0] col_mask(input int j);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = ((data_pos(i) >> j) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_col
    localparam logic [DATA_W-1:0] MASK = col_mask(j);
    assign ham[j] = ^(data & MASK);
  end

  assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_rmw_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data_out,
  output logic              sbe,
  output logic              mbe
);
  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  syn;
  logic              par_err;
  logic              in_range;
  logic [DATA_W-1:0] flip;

  ecc_encoder u_enc (.data(code[DATA_W-1:0]), .chk(recalc));

  assign syn      = code[DATA_W +: HAM_W] ^ recalc[HAM_W-1:0];
  assign par_err  = ^code;
  assign in_range = int'(syn) <= MAX_POS;
  assign sbe      = par_err && in_range;
  assign mbe      = (syn != '0 && !par_err) || (par_err && !in_range);

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int P = data_pos(i);
    assign flip[i] = sbe && (syn == HAM_W'(P));
  end

  assign data_out = code[DATA_W-1:0] ^ flip;
endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] old_d,
  input  logic [LANES*LANE_W-1:0] new_d,
  input  logic [LANES-1:0]        lane_en,
  output logic [LANES*LANE_W-1:0] merged
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*LANE_W +: LANE_W] = lane_en[b] ? new_d[b*LANE_W +: LANE_W]
                                                   : old_d[b*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_narrow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BYTES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CODE_W-1:0] mem_wdata,
  input  logic [CODE_W-1:0] mem_rdata,
  output logic              err_irq,
  output logic              err_corr,
  output logic [ADDR_W-1:0] err_addr,
  input  logic              err_clr
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_B = BYTES / 2;

  rmw_state_e        state_q;
  logic              op_we_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [BYTES-1:0]  op_be_q;
  logic              rsp_valid_q, mem_rd_q, mem_wr_q, irq_q, corr_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic [ADDR_W-1:0] mem_addr_q, err_addr_q;
  logic [CODE_W-1:0] mem_wdata_q;

  logic [DATA_W-1:0] dmask, wdata_m, cor_data, merged, enc_in;
  logic [BYTES-1:0]  bmask, be_m;
  logic [CODE_W-1:0] rd_word;
  logic [CHK_W-1:0]  enc_chk;
  logic              accept, full_wr, sbe, mbe;

  // lane masks for the selected width
  assign dmask   = cfg_narrow ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
  assign bmask   = cfg_narrow ? {{HALF_B{1'b0}}, {HALF_B{1'b1}}} : '1;
  assign wdata_m = req_wdata & dmask;
  assign be_m    = req_be & bmask;
  assign full_wr = (be_m == bmask);

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign rd_word = {mem_rdata[DATA_W +: CHK_W], mem_rdata[DATA_W-1:0] & dmask};

  ecc_corrector u_cor (.code(rd_word), .data_out(cor_data), .sbe(sbe), .mbe(mbe));

  byte_merge #(.LANES(BYTES), .LANE_W(BYTE_W)) u_merge (
    .old_d(cor_data), .new_d(op_wdata_q), .lane_en(op_be_q), .merged(merged)
  );

  // one encoder shared by the direct write and the write-back
  assign enc_in = (state_q == ST_CHECK) ? merged : wdata_m;
  ecc_encoder u_enc (.data(enc_in), .chk(enc_chk));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_we_q     <= 1'b0;
      op_wdata_q  <= '0;
      op_be_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      mem_rd_q    <= 1'b0;
      mem_wr_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      irq_q       <= 1'b0;
      corr_q      <= 1'b0;
      err_addr_q  <= '0;
    end else begin
      mem_rd_q    <= 1'b0;
      mem_wr_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      if (err_clr) begin
        irq_q  <= 1'b0;
        corr_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_we_q    <= req_we;
            op_wdata_q <= wdata_m;
            op_be_q    <= be_m;
            mem_addr_q <= req_addr;
            if (req_we && full_wr) begin
              mem_wr_q    <= 1'b1;
              mem_wdata_q <= {enc_chk, wdata_m};
            end else begin
              mem_rd_q <= 1'b1;
              state_q  <= ST_READ;
            end
          end
        end
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (sbe || mbe) err_addr_q <= mem_addr_q;
          if (sbe) corr_q <= 1'b1;
          if (mbe) irq_q  <= 1'b1;
          if (op_we_q) begin
            mem_wr_q    <= 1'b1;
            mem_wdata_q <= {enc_chk, merged};
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= cor_data;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign mem_rd    = mem_rd_q;
  assign mem_wr    = mem_wr_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign err_irq   = irq_q;
  assign err_corr  = corr_q;
  assign err_addr  = err_addr_q;

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R2
  rmw_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && op_we_q) |=> ##1 (mem_wr && mem_addr == $past(mem_addr, 2)));

  // R2
  rmw_blocks_host_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !req_ready);

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && cfg_narrow) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));

  // R6
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !op_we_q) |=> ##1 rsp_valid);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !err_clr) |=> err_irq);
endmodule

// File: tb/ecc_rmw_engine_bench.sv
`timescale 1ns/1ps
module ecc_rmw_engine_bench;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_narrow = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, err_clr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_rd, mem_wr, err_irq, err_corr;
  logic [63:0] rsp_rdata;
  logic [AW-1:0] mem_addr, err_addr;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata;

  logic [71:0] mem [WORDS];
  logic [63:0] ref_mem [WORDS];
  int n_rd = 0, n_wr = 0;
  int checks = 0, fails = 0;
  bit esbe = 0, embe = 0;
  logic [AW-1:0] eaddr = '0;

  always #2.5 clk = ~clk;

  ecc_rmw_engine #(.ADDR_W(AW)) u_ecc_rmw_engine (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_irq(err_irq), .err_corr(err_corr), .err_addr(err_addr), .err_clr(err_clr)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_rd) n_rd <= n_rd + 1;
    if (mem_wr) n_wr <= n_wr + 1;
  end

  // check field per R9, built from a position-indexed codeword
  function automatic logic [7:0] b_ecc(input logic [63:0] d);
    logic [71:1] cw;
    logic [7:0] c;
    int k;
    cw = '0; k = 0; c = '0;
    for (int p = 1; p <= 71; p++)
      if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
    for (int j = 0; j < 7; j++)
      for (int p = 1; p <= 71; p++)
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [71:0] b_code(input logic [63:0] d);
    return {b_ecc(d), d};
  endfunction

  function automatic logic [63:0] b_merge(input logic [63:0] o, input logic [63:0] n,
                                          input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  function automatic int pick_bit(input bit narrow);
    int b;
    if (narrow) begin
      b = int'($urandom % 40);
      if (b >= 32) b = b + 32;
    end else b = int'($urandom % 72);
    return b;
  endfunction

  function automatic logic [71:0] make_flip(input int kind, input bit narrow);
    logic [71:0] f;
    int b1, b2;
    f = '0;
    if (kind == 0) return f;
    b1 = pick_bit(narrow);
    f[b1] = 1'b1;
    if (kind == 2) begin
      b2 = pick_bit(narrow);
      while (b2 == b1) b2 = pick_bit(narrow);
      f[b2] = 1'b1;
    end
    return f;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    esbe = 0; embe = 0;
    check(err_irq == 1'b0 && err_corr == 1'b0, "R7", "flags after clear",
          {70'd0, err_irq, err_corr}, 72'd0);
  endtask

  task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [63:0] d,
                        input logic [7:0] be, input logic [71:0] flip, input int kind);
    logic [63:0] dm, raw, cor, got;
    logic [7:0] bm;
    logic [71:0] exp_mem;
    bit full, seen;
    int rd0, wr0, low, exp_low, exp_rd;
    string tagw, tagm;
    dm = cfg_narrow ? {32'd0, d[31:0]} : d;
    bm = cfg_narrow ? {4'd0, be[3:0]} : be;
    full = cfg_narrow ? (bm == 8'h0F) : (bm == 8'hFF);
    tagw = cfg_narrow ? "R5" : (full ? "R1" : "R2");
    @(negedge clk);
    mem[a] = mem[a] ^ flip;
    raw = cfg_narrow ? {32'd0, mem[a][31:0]} : mem[a][63:0];
    while (!req_ready) @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    low = 0; seen = 0; got = '0;
    for (int i = 0; i < 8; i++) begin
      if (rsp_valid) begin seen = 1; got = rsp_rdata; end
      if (!req_ready) low++;
      @(negedge clk);
    end
    cor = ref_mem[a];
    if (we && full) begin
      ref_mem[a] = dm; exp_rd = 0; exp_low = 0;
    end else begin
      exp_rd = 1; exp_low = 2;
      if (kind == 2) cor = raw;
      if (kind == 1) begin esbe = 1; eaddr = a; end
      if (kind == 2) begin embe = 1; eaddr = a; end
      if (we) ref_mem[a] = b_merge(cor, dm, bm);
    end
    exp_mem = we ? b_code(ref_mem[a]) : (b_code(ref_mem[a]) ^ flip);
    tagm = (kind == 2 && exp_rd == 1) ? "R4" : ((kind == 1 && exp_rd == 1) ? "R3" : tagw);
    check(n_rd - rd0 == exp_rd, tagw, "array reads", 72'(n_rd - rd0), 72'(exp_rd));
    check(n_wr - wr0 == int'(we), tagw, "array writes", 72'(n_wr - wr0), 72'(we));
    check(low == exp_low, tagw, "ready-low cycles", 72'(low), 72'(exp_low));
    check(mem[a] === exp_mem, tagm, "stored word (R9 layout)", mem[a], exp_mem);
    if (!we) begin
      check(seen && got === cor, (kind == 2) ? "R4" : "R6", "read data",
            {7'd0, seen, got}, {8'd1, cor});
      mem[a] = b_code(ref_mem[a]);
    end
    check(err_corr == esbe, "R3", "corrected flag", 72'(err_corr), 72'(esbe));
    check(err_irq == embe, "R4", "interrupt flag", 72'(err_irq), 72'(embe));
    if (esbe || embe) check(err_addr == eaddr, "R7", "error address", 72'(err_addr), 72'(eaddr));
  endtask

  task automatic random_ops(input int n);
    for (int k = 0; k < n; k++) begin
      bit we;
      int kind, r;
      logic [7:0] be;
      we = ($urandom % 3) != 0;
      r = int'($urandom % 3);
      be = (r == 0) ? 8'hFF : ((r == 1 && cfg_narrow) ? 8'h0F : 8'($urandom));
      r = int'($urandom % 6);
      kind = (r < 3) ? 0 : ((r < 5) ? 1 : 2);
      run_op(we, AW'($urandom), {$urandom, $urandom}, be, make_flip(kind, cfg_narrow), kind);
      if (($urandom % 8) == 0) clear_flags();
    end
  endtask

  initial begin
    logic [71:0] f;
    void'($urandom(32'h5EED_1234));
    for (int a = 0; a < WORDS; a++) begin
      ref_mem[a] = {$urandom, $urandom};
      mem[a] = b_code(ref_mem[a]);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(req_ready == 1'b1, "R8", "ready after reset", 72'(req_ready), 72'd1);
    check({rsp_valid, mem_rd, mem_wr, err_irq, err_corr} == 5'd0, "R8", "idle outputs",
          72'({rsp_valid, mem_rd, mem_wr, err_irq, err_corr}), 72'd0);
    // R1 full write
    run_op(1, 6'd1, 64'h0123_4567_89AB_CDEF, 8'hFF, '0, 0);
    // R2 partial write, low half
    run_op(1, 6'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, '0, 0);
    // R2 empty mask with a repaired data bit (R3)
    f = '0; f[5] = 1'b1;
    run_op(1, 6'd3, 64'hDEAD_BEEF_0000_1111, 8'h00, f, 1);
    // R3 overall parity bit flipped on a read
    f = '0; f[71] = 1'b1;
    run_op(0, 6'd4, '0, 8'h00, f, 1);
    // R3 Hamming bit flipped on a partial write
    f = '0; f[64] = 1'b1;
    run_op(1, 6'd7, 64'hA5A5_A5A5_A5A5_A5A5, 8'h3C, f, 1);
    clear_flags();
    // R4 / R6 double error on a read
    f = '0; f[0] = 1'b1; f[70] = 1'b1;
    run_op(0, 6'd5, '0, 8'h00, f, 2);
    clear_flags();
    // R4 double error on a partial write: merged raw data stored
    f = '0; f[10] = 1'b1; f[20] = 1'b1;
    run_op(1, 6'd6, 64'h7700_0000_0000_0000, 8'h80, f, 2);
    clear_flags();
    random_ops(400);
    clear_flags();
    // R5 narrow mode
    @(negedge clk); cfg_narrow = 1'b1;
    for (int a = 0; a < WORDS; a++) begin
      ref_mem[a] = {32'd0, $urandom};
      mem[a] = b_code(ref_mem[a]);
    end
    run_op(1, 6'd9, 64'hCAFE_F00D_1357_9BDF, 8'h0F, '0, 0);
    run_op(1, 6'd10, 64'hFFFF_FFFF_2468_ACE0, 8'hF0, '0, 0);
    run_op(1, 6'd11, 64'h1111_2222_3333_4444, 8'hF3, '0, 0);
    random_ops(150);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule